// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block runs on the host side of a parallel flash device. Another agent first issues a program or erase command sequence to the flash. This block then decides when that operation has ended. It reads the flash status word over and over through a simple synchronous read port, and it reports whether the operation completed, was found erase-suspended, or never finished within a poll budget.

A request gives the operation type, the address to poll, the expected data byte and the maximum number of reads. For a program, the poll address is the programmed location. For an erase, it is any address inside a sector chosen for erasure. The controller compares each status word with the one before it. A toggling busy bit means the operation is still running. A stable busy bit, together with the right value on the data-polling bit, means it has stopped. Bit 7 can settle out of step with the lower bits, so a stop seen on one read is only accepted after one more read confirms it. The word from that confirming read is the one reported.

Top module: `flashPollTop`

## Requirements
- R1: While idle, `reqValid` high for one cycle starts an operation. Every poll read then drives `rdEn` high for exactly one cycle with `rdAddr` equal to the requested address. The flash returns the word on `rdData` in the cycle after `rdEn`, and reads are never issued in consecutive cycles.
- R2: No outcome is decided from the first read of an operation. On any later read, bit 6 differing from bit 6 of the previous read means the operation is still busy, and polling continues.
- R3: For a program operation (`reqIsErase`=0), a read whose bit 6 equals the previous read's bit 6 and whose bit 7 equals bit 7 of `reqData` is a stop candidate. Bit 2 plays no part in this case.
- R4: For an erase operation (`reqIsErase`=1), a read whose bit 6 is stable against the previous read and whose bit 7 is 1 is a stop candidate.
- R5: A stop candidate is accepted only if the next read is also a stop candidate. If that next read is not a candidate, polling continues and a fresh pair of candidates is needed. On acceptance, `resultData` carries the full 8-bit word of the confirming read.
- R6: For an erase, when the confirming read is accepted and its bit 2 differs from bit 2 of the read before it, `suspPulse` is raised instead of `donePulse`.
- R7: If the read numbered `maxPolls` is evaluated without an accepted outcome, `timeoutPulse` is raised and `resultData` holds that last word. An acceptance on that same read wins over the timeout.
- R8: `donePulse`, `suspPulse` and `timeoutPulse` are one-cycle pulses, at most one at a time. Each appears 3 cycles after the `rdEn` cycle of the read that decided it, and `busy` is low in the pulse cycle.
- R9: A `reqValid` pulse while `busy` is high is ignored. The poll address and the operation's outcome stay those of the running request.
- R10: After reset, `busy`, `rdEn` and all three outcome pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start request, taken only while idle |
| reqIsErase | input | 1 | 1 = erase operation, 0 = program operation |
| reqAddr | input | ADDR_W | Address to poll |
| reqData | input | 8 | Expected programmed byte (bit 7 used) |
| maxPolls | input | CNT_W | Read budget before timeout |
| rdEn | output | 1 | Read strobe to the flash port |
| rdAddr | output | ADDR_W | Read address |
| rdData | input | 8 | Status word, valid the cycle after rdEn |
| busy | output | 1 | An operation is being polled |
| donePulse | output | 1 | Operation completed |
| suspPulse | output | 1 | Erase found suspended |
| timeoutPulse | output | 1 | Budget exhausted |
| resultData | output | 8 | Last status word, valid with any outcome pulse |

## Verification
Each poll takes three cycles: the read strobe, the returned word, and the evaluation. An outcome pulse is therefore due exactly 3 cycles after the strobe of the read that decided it. The bench notes the cycle of every read strobe it sees and, at the pulse, checks that the gap is 3 and that the read count matches the status sequence it fed in. The flash model answers one cycle after each strobe, and all sampling takes place on the falling edge. That keeps every comparison clear of the edge at which the design updates.

// File: rtl/flashPollPkg.sv
package flashPollPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_CAPT,
    ST_EVAL
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic capture;
  } pollStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic eraseOp;
    logic busyToggle;
    logic suspToggle;
    logic trueData;
    logic cmpReady;
    logic limitHit;
  } pollStat_t;
endpackage

// File: rtl/flashPollData.sv
module flashPollData
  import flashPollPkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobe_t       strobe,
  input  logic              reqIsErase,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic [CNT_W-1:0]  maxPolls,
  input  logic [7:0]        rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        resultData,
  output pollStat_t         stat
);
  localparam int BUSY_BIT = 6;
  localparam int POLL_BIT = 7;
  localparam int SUSP_BIT = 2;

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  limitQ;
  logic [CNT_W-1:0]  pollCnt;
  logic [7:0]        currWord;
  logic [7:0]        prevWord;
  logic              expBit;
  logic              eraseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      limitQ   <= '0;
      pollCnt  <= '0;
      currWord <= '0;
      prevWord <= '0;
      expBit   <= 1'b0;
      eraseQ   <= 1'b0;
    end else if (strobe.load) begin
      addrQ    <= reqAddr;
      limitQ   <= maxPolls;
      pollCnt  <= '0;
      currWord <= '0;
      prevWord <= '0;
      expBit   <= reqData[POLL_BIT];
      eraseQ   <= reqIsErase;
    end else if (strobe.capture) begin
      prevWord <= currWord;
      currWord <= rdData;
      pollCnt  <= pollCnt + 1'b1;
    end
  end

  assign rdAddr     = addrQ;
  assign resultData = currWord;

  always_comb begin
    stat.eraseOp    = eraseQ;
    stat.busyToggle = currWord[BUSY_BIT] ^ prevWord[BUSY_BIT];
    stat.suspToggle = currWord[SUSP_BIT] ^ prevWord[SUSP_BIT];
    stat.trueData   = eraseQ ? currWord[POLL_BIT] : (currWord[POLL_BIT] == expBit);
    stat.cmpReady   = pollCnt >= CNT_W'(2);
    stat.limitHit   = pollCnt >= limitQ;
  end
endmodule

// File: rtl/flashPollCtrl.sv
module flashPollCtrl
  import flashPollPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  pollStat_t   stat,
  output pollStrobe_t strobe,
  output logic        rdEn,
  output logic        busy,
  output logic        donePulse,
  output logic        suspPulse,
  output logic        timeoutPulse
);
  pollState_t state;
  logic       pending;
  logic       candidate;

  assign candidate      = stat.cmpReady && !stat.busyToggle && stat.trueData;
  assign strobe.load    = (state == ST_IDLE) && reqValid;
  assign strobe.capture = (state == ST_CAPT);
  assign rdEn           = (state == ST_ISSUE);
  assign busy           = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      pending      <= 1'b0;
      donePulse    <= 1'b0;
      suspPulse    <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      donePulse    <= 1'b0;
      suspPulse    <= 1'b0;
      timeoutPulse <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          pending <= 1'b0;
          if (reqValid) state <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_CAPT;
        ST_CAPT:  state <= ST_EVAL;
        ST_EVAL: begin
          if (candidate && pending) begin
            state <= ST_IDLE;
            if (stat.eraseOp && stat.suspToggle) suspPulse <= 1'b1;
            else donePulse <= 1'b1;
          end else begin
            pending <= candidate;
            if (stat.limitHit) begin
              state        <= ST_IDLE;
              timeoutPulse <= 1'b1;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flashPollTop.sv
module flashPollTop
  import flashPollPkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsErase,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic [CNT_W-1:0]  maxPolls,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic              busy,
  output logic              donePulse,
  output logic              suspPulse,
  output logic              timeoutPulse,
  output logic [7:0]        resultData
);
  pollStrobe_t strobe;
  pollStat_t   stat;

  flashPollCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .stat         (stat),
    .strobe       (strobe),
    .rdEn         (rdEn),
    .busy         (busy),
    .donePulse    (donePulse),
    .suspPulse    (suspPulse),
    .timeoutPulse (timeoutPulse)
  );

  flashPollData #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqIsErase (reqIsErase),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .maxPolls   (maxPolls),
    .rdData     (rdData),
    .rdAddr     (rdAddr),
    .resultData (resultData),
    .stat       (stat)
  );
endmodule

// File: rtl/flashPollChecker.sv
module flashPollChecker #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              busy,
  input logic              donePulse,
  input logic              suspPulse,
  input logic              timeoutPulse
);
  p_read_spacing_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> !rdEn);

  p_idle_no_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdEn);

  p_outcome_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({donePulse, suspPulse, timeoutPulse}));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  p_outcome_after_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse || suspPulse || timeoutPulse) |-> ($past(busy) && !busy));

  p_addr_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rdAddr));
endmodule

bind flashPollTop flashPollChecker #(.ADDR_W(ADDR_W)) u_flashPollChecker (
  .clk          (clk),
  .rstN         (rstN),
  .rdEn         (rdEn),
  .rdAddr       (rdAddr),
  .busy         (busy),
  .donePulse    (donePulse),
  .suspPulse    (suspPulse),
  .timeoutPulse (timeoutPulse)
);

// File: tb/test_flashPollTop.sv
module test_flashPollTop;
  localparam int AW = 21;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqIsErase = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqData = '0;
  logic [CW-1:0] maxPolls = '0;
  logic          rdEn;
  logic [AW-1:0] rdAddr;
  logic [7:0]    rdData = '0;
  logic          busy, donePulse, suspPulse, timeoutPulse;
  logic [7:0]    resultData;

  flashPollTop #(.ADDR_W(AW), .CNT_W(CW)) i_flashPollTop (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsErase(reqIsErase),
    .reqAddr(reqAddr), .reqData(reqData), .maxPolls(maxPolls),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .busy(busy),
    .donePulse(donePulse), .suspPulse(suspPulse), .timeoutPulse(timeoutPulse),
    .resultData(resultData)
  );

  always #5 clk = ~clk;

  typedef struct {
    int       kind;   // 0 done, 1 suspended, 2 timeout
    logic [7:0] data;
    int       reads;
    string    tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [7:0] rspQ[$];
  int         nTests = 0;
  int         nFail = 0;
  int         cycle = 0;
  int         lastRd = 0;
  int         readsOp = 0;
  logic [AW-1:0] curAddr = '0;

  task automatic check(input string tag, input logic ok, input string what,
                       input int act, input int expv);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // flash model: answers one cycle after each strobe
  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (rdEn && rspQ.size() > 0) rdData <= rspQ.pop_front();
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rdEn) begin
        readsOp++;
        lastRd = cycle;
        check("R1", rdAddr == curAddr, "read address", int'(rdAddr), int'(curAddr));
      end
      if (rstN && (donePulse || suspPulse || timeoutPulse)) begin
        int k;
        k = donePulse ? 0 : (suspPulse ? 1 : 2);
        if (expQ.size() == 0) begin
          check("R9", 1'b0, "unexpected outcome", k, -1);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(e.tag, k == e.kind, "outcome kind", k, e.kind);
          check(e.tag, resultData == e.data, "result word", int'(resultData), int'(e.data));
          check(e.tag, readsOp == e.reads, "read count", readsOp, e.reads);
          check("R8", cycle - lastRd == 3, "pulse latency", cycle - lastRd, 3);
          check("R8", !busy, "busy in pulse cycle", int'(busy), 0);
        end
        readsOp = 0;
      end
    end
  end

  task automatic runOp(input logic erase, input logic [AW-1:0] addr,
                       input logic [7:0] expd, input int maxp,
                       input logic [7:0] seq[], input int kind,
                       input logic [7:0] data, input string tag,
                       input logic poke);
    expItem_t e;
    int waitCnt;
    foreach (seq[i]) rspQ.push_back(seq[i]);
    e.kind = kind; e.data = data; e.reads = seq.size(); e.tag = tag;
    expQ.push_back(e);
    curAddr = addr;
    @(negedge clk);
    reqValid = 1'b1; reqIsErase = erase; reqAddr = addr; reqData = expd;
    maxPolls = CW'(maxp);
    @(negedge clk);
    reqValid = 1'b0;
    if (poke) begin
      // R9: second request while busy must be ignored
      repeat (4) @(negedge clk);
      reqValid = 1'b1; reqIsErase = ~erase; reqAddr = ~addr; reqData = ~expd;
      maxPolls = CW'(1);
      @(negedge clk);
      reqValid = 1'b0;
    end
    waitCnt = 0;
    while (expQ.size() > 0 && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
    end
    if (expQ.size() > 0) begin
      check(tag, 1'b0, "no outcome", 0, kind);
      expQ.delete();
    end
    rspQ.delete();
    repeat (3) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {busy, rdEn, donePulse, suspPulse, timeoutPulse} == 5'b0,
          "reset outputs", int'({busy, rdEn, donePulse, suspPulse, timeoutPulse}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", !busy && !rdEn, "idle after reset", int'(busy), 0);

    // R3 program, complemented bit7 while toggling; R9 poke during it
    runOp(1'b0, 21'h01234, 8'hA5, 20, '{8'h00, 8'h40, 8'h00, 8'hA5, 8'hA5},
          0, 8'hA5, "R3", 1'b1);
    // R2/R3 expected bit7 = 0, toggle on bit6 blocks stop until stable
    runOp(1'b0, 21'h00010, 8'h12, 20, '{8'h80, 8'hC0, 8'h12, 8'h12, 8'h12},
          0, 8'h12, "R2", 1'b0);
    // R5 failed confirmation restarts the pair
    runOp(1'b0, 21'h1ABCD, 8'h80, 20,
          '{8'h00, 8'h40, 8'hC0, 8'h00, 8'h00, 8'h80, 8'h80},
          0, 8'h80, "R5", 1'b0);
    // R4 erase completion
    runOp(1'b1, 21'h0F000, 8'h00, 20, '{8'h00, 8'h44, 8'h00, 8'hFF, 8'hFF, 8'hFF},
          0, 8'hFF, "R4", 1'b0);
    // R6 erase suspended: bit2 toggles while bit6 stable
    runOp(1'b1, 21'h0F100, 8'h00, 20, '{8'h44, 8'h00, 8'h44, 8'hC4, 8'hC0},
          1, 8'hC0, "R6", 1'b0);
    // R6 program ignores bit2 toggle
    runOp(1'b0, 21'h00777, 8'h80, 20, '{8'h00, 8'h40, 8'hC4, 8'hC0},
          0, 8'hC0, "R6", 1'b0);
    // R7 timeout after budget
    runOp(1'b0, 21'h00500, 8'h00, 4, '{8'h80, 8'hC0, 8'h80, 8'hC0},
          2, 8'hC0, "R7", 1'b0);
    // R7 acceptance on the last budgeted read wins
    runOp(1'b0, 21'h00600, 8'h12, 5, '{8'h80, 8'hC0, 8'h12, 8'h12, 8'h12},
          0, 8'h12, "R7", 1'b0);

    repeat (5) @(negedge clk);
    check("R8", !busy && !rdEn, "idle at end", int'(busy), 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule